// File: doc/BRIEF.md
# Dead-band charge accumulation filter

This block sits between a converter that reports sense-resistor voltage as signed samples and the coulomb counter that totals them. Each valid sample is a 16-bit two's-complement value in units of 6 µV. Positive samples stand for charging current and negative samples stand for discharging current. The block passes a sample's magnitude into one of two capacity accumulators only when that magnitude reaches a programmable threshold. Small offset counts therefore never build up into the totals, no matter how long no current flows.

The threshold arrives on a configuration input that a nonvolatile store would load. A threshold of zero turns the dead band off, and every sample is then accumulated. The input range that can be measured accurately ends at 100 mV, which is code 16666. A larger magnitude raises a sticky over-range flag and is clamped to that code before it is added. Both accumulators are unsigned and stop at their all-ones value instead of wrapping.

Top module: `deadband_accum`

## Requirements
- R1: While reset is asserted and after it is released, both accumulators read zero and the over-range flag is low.
- R2: For a valid positive sample whose magnitude is at or above the threshold, the charge accumulator grows by that magnitude at the next clock edge and the discharge accumulator holds.
- R3: For a valid negative sample whose magnitude is at or above the threshold, the discharge accumulator grows by the magnitude (the negated sample) at the next clock edge and the charge accumulator holds.
- R4: For a valid sample whose magnitude is below a nonzero threshold, neither accumulator changes, in either direction and over any number of samples.
- R5: A sample whose magnitude equals the threshold exactly is accumulated.
- R6: When the threshold is zero, every valid sample is accumulated. A zero sample adds nothing.
- R7: A valid sample whose magnitude exceeds 16666 sets the over-range flag, which then stays set until reset. The amount added for that sample is 16666, and this includes the sample -32768.
- R8: Each accumulator saturates at 2^ACC_W-1 and never wraps or decreases.
- R9: The compare uses the threshold value present on the input in the same cycle as the valid sample. A new value therefore takes effect on the next valid sample.
- R10: In a cycle without the valid strobe, neither accumulator changes and the flag is not set, whatever the sample value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_cfg_i | input | THR_W (16) | Dead-band threshold in 6 µV units; 0 disables the filter |
| sample_i | input | SAMPLE_W (16) | Signed sense-voltage sample in 6 µV units |
| sample_vld_i | input | 1 | One-cycle strobe marking a valid sample |
| chg_acc_o | output | ACC_W (32) | Saturating charge total |
| dis_acc_o | output | ACC_W (32) | Saturating discharge total |
| ovr_o | output | 1 | Sticky over-range flag |

## Verification
Two functions can act on the same sample: the over-range clamp and the accumulator saturation. The bench builds the accumulators with a narrow width, drives repeated full-scale and beyond-range samples in both directions, and makes the clamped addition cross the saturation limit. In those cycles the flag, the clamped step and the stop at all-ones are all compared against a behavioural model on every clock. The bench also changes the threshold in the same cycle as a sample, to confirm that the compare uses the value present in that cycle.

// File: rtl/deadband_accum.sv
module deadband_accum #(
  parameter int SAMPLE_W = 16,
  parameter int THR_W    = 16,
  parameter int ACC_W    = 32,
  parameter int LIMIT    = 16666
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [THR_W-1:0]    thr_cfg_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_vld_i,
  output logic [ACC_W-1:0]    chg_acc_o,
  output logic [ACC_W-1:0]    dis_acc_o,
  output logic                ovr_o
);

  localparam int CMP_W = (SAMPLE_W > THR_W) ? SAMPLE_W : THR_W;
  localparam logic [SAMPLE_W-1:0] LIM = LIMIT[SAMPLE_W-1:0];

  logic [SAMPLE_W-1:0] mag, amt;
  logic                over, pass, is_pos, is_neg;
  logic [ACC_W:0]      chg_sum, dis_sum;

  assign mag    = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
  assign over   = mag > LIM;
  assign amt    = over ? LIM : mag;
  assign pass   = (thr_cfg_i == '0) ||
                  (CMP_W'(mag) >= CMP_W'(thr_cfg_i));
  assign is_neg = sample_i[SAMPLE_W-1];
  assign is_pos = !is_neg && (sample_i != '0);

  assign chg_sum = {1'b0, chg_acc_o} + (ACC_W+1)'(amt);
  assign dis_sum = {1'b0, dis_acc_o} + (ACC_W+1)'(amt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_acc_o <= '0;
      dis_acc_o <= '0;
      ovr_o     <= 1'b0;
    end else if (sample_vld_i) begin
      if (over) ovr_o <= 1'b1;
      if (pass && is_pos)
        chg_acc_o <= chg_sum[ACC_W] ? '1 : chg_sum[ACC_W-1:0];
      if (pass && is_neg)
        dis_acc_o <= dis_sum[ACC_W] ? '1 : dis_sum[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/deadband_accum_chk.sv
module deadband_accum_chk #(
  parameter int SAMPLE_W = 16,
  parameter int THR_W    = 16,
  parameter int ACC_W    = 32,
  parameter int LIMIT    = 16666
) (
  input logic                clk,
  input logic                rst_n,
  input logic [THR_W-1:0]    thr_cfg_i,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic                sample_vld_i,
  input logic [ACC_W-1:0]    chg_acc_o,
  input logic [ACC_W-1:0]    dis_acc_o,
  input logic                ovr_o
);

  logic signed [SAMPLE_W:0] s_ext;
  logic [SAMPLE_W:0]        abs_v;
  assign s_ext = {sample_i[SAMPLE_W-1], sample_i};
  assign abs_v = (s_ext < 0) ? SAMPLE_W'(-s_ext) : SAMPLE_W'(s_ext);

  // R10
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld_i |=> ($stable(chg_acc_o) && $stable(dis_acc_o)));

  // R7
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |=> ovr_o);

  // R8
  p_chg_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (chg_acc_o >= $past(chg_acc_o)));

  // R8
  p_dis_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dis_acc_o >= $past(dis_acc_o)));

  // R7
  p_step_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chg_acc_o - $past(chg_acc_o)) <= ACC_W'(LIMIT)));

  // R2
  p_pos_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld_i && !sample_i[SAMPLE_W-1]) |=> $stable(dis_acc_o));

  // R3
  p_neg_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld_i && sample_i[SAMPLE_W-1]) |=> $stable(chg_acc_o));

  // R4
  p_dead_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld_i && thr_cfg_i != '0 && abs_v < (SAMPLE_W+1)'(thr_cfg_i))
      |=> ($stable(chg_acc_o) && $stable(dis_acc_o)));

endmodule

bind deadband_accum deadband_accum_chk #(
  .SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .ACC_W(ACC_W), .LIMIT(LIMIT)
) chk_i (.*);

// File: tb/deadband_accum_tb.sv
module deadband_accum_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 20;
  localparam int LIM  = 16666;
  localparam longint ACC_MAX = (64'd1 << AW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] thr = '0;
  logic [15:0] smp = '0;
  logic        vld = 1'b0;
  logic [AW-1:0] chg, dis;
  logic        ovr;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  longint exp_chg = 0, exp_dis = 0;
  bit     exp_ovr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deadband_accum #(.ACC_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .thr_cfg_i(thr), .sample_i(smp),
    .sample_vld_i(vld), .chg_acc_o(chg), .dis_acc_o(dis), .ovr_o(ovr)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_chg = 0; exp_dis = 0; exp_ovr = 1'b0;
    end else if (vld) begin
      int v, m, a;
      v = $signed(smp);
      m = (v < 0) ? -v : v;
      a = (m > LIM) ? LIM : m;
      if (m > LIM) exp_ovr = 1'b1;
      if (thr == 0 || m >= int'(thr)) begin
        if (v > 0) exp_chg = (exp_chg + a > ACC_MAX) ? ACC_MAX : exp_chg + a;
        if (v < 0) exp_dis = (exp_dis + a > ACC_MAX) ? ACC_MAX : exp_dis + a;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (longint'(chg) != exp_chg || longint'(dis) != exp_dis || ovr != exp_ovr) begin
        errors++;
        $display("FAIL %s: chg=%0d dis=%0d ovr=%0b expected chg=%0d dis=%0d ovr=%0b",
                 cur_req, chg, dis, ovr, exp_chg, exp_dis, exp_ovr);
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] t, input int s);
    @(negedge clk);
    thr = t; smp = 16'(s); vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    $display("FAIL watchdog: actual=timeout expected=finish");
    errors++;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", chg, 0); chk("R1", dis, 0); chk("R1", ovr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", chg, 0); chk("R1", ovr, 0);

    cur_req = "R2"; put(100, 500);
    chk("R2", chg, 500); chk("R2", dis, 0);
    cur_req = "R3"; put(100, -300);
    chk("R3", dis, 300); chk("R3", chg, 500);

    cur_req = "R4";
    put(100, 99); put(100, -99); put(100, 1);
    for (int i = 0; i < 50; i++) put(10, (i % 2) ? 5 : -5);
    chk("R4", chg, 500); chk("R4", dis, 300);

    cur_req = "R5"; put(100, 100); put(100, -100);
    chk("R5", chg, 600); chk("R5", dis, 400);

    cur_req = "R6"; put(0, 1); put(0, -1); put(0, 3); put(0, 0);
    chk("R6", chg, 604); chk("R6", dis, 401);

    cur_req = "R10";
    @(negedge clk); smp = 16'(20000); vld = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", chg, 604); chk("R10", ovr, 0);

    cur_req = "R7"; put(0, 20000);
    chk("R7", chg, 604 + LIM); chk("R7", ovr, 1);
    put(0, -32768);
    chk("R7", dis, 401 + LIM);
    put(0, 7);
    chk("R7", ovr, 1);

    cur_req = "R9";
    put(1000, 999);
    chk("R9", chg, 611 + LIM);
    put(500, 999);
    chk("R9", chg, 1610 + LIM);

    cur_req = "R8";
    for (int i = 0; i < 70; i++) put(0, (i % 2) ? 32767 : LIM);
    for (int i = 0; i < 70; i++) put(0, (i % 2) ? -20000 : -LIM);
    chk("R8", chg, ACC_MAX); chk("R8", dis, ACC_MAX);
    put(0, 5);
    chk("R8", chg, ACC_MAX);

    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1", chg, 0); chk("R1", ovr, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule